// File: doc/BRIEF.md
# Line Transition Interrupt Unit

This block watches a bank of 24 already-filtered digital input lines and reports selected transitions to software through a level interrupt. Each line has its own rising-transition enable and its own falling-transition enable. Two global direction enables in a control register qualify those per-line masks. When any line makes a qualifying transition, the block latches an edge-pending flag. If another qualifying transition arrives while that flag is still set, the block also latches an overflow flag.

Software reaches the block through a byte-wide register port with single-cycle writes and a combinational read. Through this port it programs the masks and the control register, reads the status, and clears the flags by writing a clear register. The normal sequence is: clear both flags, then set the enables. The interrupt output is asserted only while the master enable is set and at least one flag is pending with its own interrupt enable. Writing zero to the control register stops both detection and interrupt generation.

Top module: `edge_change_irq`

## Requirements
- R1: After reset, every mask register, the control register and both flags are zero, the status reads 0x00 and `irqOut` is low.
- R2: A 0-to-1 change on a line sets the edge-pending flag (status bit 0) at the clock edge that first samples the new level. The line's bit must be set in its rising mask and control bit 3 (global rising enable) must be set. The rising masks sit at byte offsets 0x18, 0x19 and 0x1A, holding lines 0-7, 8-15 and 16-23, with bit n of a byte mapping to line 8*k+n.
- R3: A 1-to-0 change on a line sets the edge-pending flag in the same way. The line's bit must be set in its falling mask and control bit 4 (global falling enable) must be set. The falling masks sit at offsets 0x20, 0x21 and 0x22, with the same line mapping as R2.
- R4: A transition in a direction whose mask bit or global enable is clear has no effect on the status.
- R5: A qualifying transition that arrives while the edge-pending flag is set also sets the overflow flag (status bit 1).
- R6: Writing the clear register at offset 0x07 clears the edge-pending flag when bit 3 is set and clears the overflow flag when bit 2 is set. If a qualifying transition occurs in the same cycle as the clear, the set wins.
- R7: `irqOut` is high exactly when control bit 2 (master enable) is set and at least one of these holds: the edge flag is set with control bit 0 (edge interrupt enable), or the overflow flag is set with control bit 1 (overflow interrupt enable). Status bit 2 at offset 0x14 always equals `irqOut`.
- R8: Writing 0x00 to the control register (offset 0x15) drops `irqOut` at once and stops new transitions from being detected. Flags that are already latched stay set.
- R9: The mask and control registers read back what was written. Control bits 7:5 always read as zero. Any unmapped offset reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| addr | input | 6 | Byte offset for the read or write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data at `addr` (combinational) |
| lineIn | input | 24 | Filtered input lines |
| irqOut | output | 1 | Level interrupt request |

## Verification
The bench sends transitions on unmasked lines and in disabled directions. A design that ignored the per-line masks or the global enables would raise the edge flag on those. It repeats a qualifying transition while a flag is still pending, then checks that overflow comes up and that it alone drives the interrupt when only the overflow enable is set; a design that tied overflow to the edge interrupt enable would fail here. It issues a clear in the same cycle as a new transition, where a design that let the clear win would lose an event. It also writes zero to the control register while flags are latched, expecting the interrupt to drop while the status keeps its flags.

// File: rtl/edgeirq_pkg.sv
package edgeirq_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BANKS = 3;
  localparam int LINE_W    = BYTE_W * NUM_BANKS;
  localparam int ADDR_W    = 6;

  localparam logic [ADDR_W-1:0] RISE_BASE = 6'h18;
  localparam logic [ADDR_W-1:0] FALL_BASE = 6'h20;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 6'h15;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 6'h14;
  localparam logic [ADDR_W-1:0] CLR_ADDR  = 6'h07;

  // control bit positions
  localparam int CTRL_FALL   = 4;
  localparam int CTRL_RISE   = 3;
  localparam int CTRL_MASTER = 2;
  localparam int CTRL_OVFIE  = 1;
  localparam int CTRL_EDGEIE = 0;
  localparam int CTRL_USED   = 5;

  // clear register bit positions
  localparam int CLR_EDGE = 3;
  localparam int CLR_OVF  = 2;

  typedef struct packed {
    logic [NUM_BANKS-1:0] riseWr;
    logic [NUM_BANKS-1:0] fallWr;
    logic                 ctrlWr;
    logic                 edgeClr;
    logic                 ovfClr;
  } strobe_t;
endpackage

// File: rtl/edgeirq_ctrl.sv
module edgeirq_ctrl
  import edgeirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              hitAny,
  input  logic [BYTE_W-1:0] ctrlReg,
  output strobe_t           strb,
  output logic              edgePending,
  output logic              ovfFlag,
  output logic              irqOut
);
  // write decode into strobes
  always_comb begin
    strb = '0;
    if (wrEn) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (addr == RISE_BASE + ADDR_W'(b)) strb.riseWr[b] = 1'b1;
        if (addr == FALL_BASE + ADDR_W'(b)) strb.fallWr[b] = 1'b1;
      end
      strb.ctrlWr = (addr == CTRL_ADDR);
      if (addr == CLR_ADDR) begin
        strb.edgeClr = wrData[CLR_EDGE];
        strb.ovfClr  = wrData[CLR_OVF];
      end
    end
  end

  // latched flags: a new event beats a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgePending <= 1'b0;
      ovfFlag     <= 1'b0;
    end else begin
      if (hitAny)            edgePending <= 1'b1;
      else if (strb.edgeClr) edgePending <= 1'b0;
      if (hitAny && edgePending) ovfFlag <= 1'b1;
      else if (strb.ovfClr)      ovfFlag <= 1'b0;
    end
  end

  always_comb begin
    irqOut = ctrlReg[CTRL_MASTER] &
             ((edgePending & ctrlReg[CTRL_EDGEIE]) | (ovfFlag & ctrlReg[CTRL_OVFIE]));
  end

  p_edge_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    hitAny |=> edgePending);
  p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hitAny && edgePending) |=> ovfFlag);
  p_ovf_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(edgePending && hitAny));
  p_edge_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.edgeClr && !hitAny) |=> !edgePending);
  p_ovf_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ovfClr && !(hitAny && edgePending)) |=> !ovfFlag);
  p_irq_master_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[CTRL_MASTER] |-> !irqOut);
endmodule

// File: rtl/edgeirq_datapath.sv
module edgeirq_datapath
  import edgeirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LINE_W-1:0] lineIn,
  input  logic              edgePending,
  input  logic              ovfFlag,
  input  logic              irqOut,
  output logic              hitAny,
  output logic [BYTE_W-1:0] ctrlReg,
  output logic [BYTE_W-1:0] rdData
);
  localparam logic [BYTE_W-1:0] CTRL_KEEP = BYTE_W'((1 << CTRL_USED) - 1);

  logic [LINE_W-1:0] riseVec, fallVec, linePrev;
  logic [LINE_W-1:0] riseHit, fallHit;

  genvar g;
  generate
    for (g = 0; g < NUM_BANKS; g++) begin : gBank
      always_ff @(posedge clk) begin
        if (!rstN) begin
          riseVec[g*BYTE_W +: BYTE_W] <= '0;
          fallVec[g*BYTE_W +: BYTE_W] <= '0;
        end else begin
          if (strb.riseWr[g]) riseVec[g*BYTE_W +: BYTE_W] <= wrData;
          if (strb.fallWr[g]) fallVec[g*BYTE_W +: BYTE_W] <= wrData;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      linePrev <= '0;
    end else begin
      if (strb.ctrlWr) ctrlReg <= wrData & CTRL_KEEP;
      linePrev <= lineIn;
    end
  end

  always_comb begin
    riseHit = lineIn & ~linePrev & riseVec & {LINE_W{ctrlReg[CTRL_RISE]}};
    fallHit = ~lineIn & linePrev & fallVec & {LINE_W{ctrlReg[CTRL_FALL]}};
    hitAny  = |(riseHit | fallHit);
  end

  always_comb begin
    rdData = '0;
    if (addr == CTRL_ADDR) rdData = ctrlReg;
    if (addr == STAT_ADDR) rdData = {{(BYTE_W-3){1'b0}}, irqOut, ovfFlag, edgePending};
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr == RISE_BASE + ADDR_W'(b)) rdData = riseVec[b*BYTE_W +: BYTE_W];
      if (addr == FALL_BASE + ADDR_W'(b)) rdData = fallVec[b*BYTE_W +: BYTE_W];
    end
  end

  p_hit_needs_global_r4: assert property (@(posedge clk) disable iff (!rstN)
    hitAny |-> (ctrlReg[CTRL_RISE] || ctrlReg[CTRL_FALL]));
  p_ctrl_readback_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctrlWr |=> (ctrlReg == ($past(wrData) & CTRL_KEEP)));
  p_quiet_lines_r4: assert property (@(posedge clk) disable iff (!rstN)
    $stable(lineIn) |-> !hitAny);
endmodule

// File: rtl/edge_change_irq.sv
module edge_change_irq
  import edgeirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic [LINE_W-1:0] lineIn,
  output logic              irqOut
);
  strobe_t           strb;
  logic              hitAny, edgePending, ovfFlag;
  logic [BYTE_W-1:0] ctrlReg;

  edgeirq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .hitAny(hitAny), .ctrlReg(ctrlReg), .strb(strb),
    .edgePending(edgePending), .ovfFlag(ovfFlag), .irqOut(irqOut)
  );

  edgeirq_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .addr(addr),
    .lineIn(lineIn), .edgePending(edgePending), .ovfFlag(ovfFlag),
    .irqOut(irqOut), .hitAny(hitAny), .ctrlReg(ctrlReg), .rdData(rdData)
  );
endmodule

// File: tb/tb_edge_change_irq.sv
module tb_edge_change_irq;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_WR = 2'd0, OP_LN = 2'd1, OP_RD = 2'd2, OP_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [5:0]  addr;
    logic [23:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VEC [NV] = '{
    '{OP_RD,  6'h14, 24'h00, 4'd1},   // R1 status clear
    '{OP_RD,  6'h15, 24'h00, 4'd1},   // R1 control clear
    '{OP_IRQ, 6'h00, 24'h00, 4'd1},   // R1 irq low
    '{OP_WR,  6'h18, 24'h01, 4'd2},   // rise mask line0
    '{OP_WR,  6'h15, 24'h0D, 4'd2},   // rise global, master, edge ie
    '{OP_RD,  6'h18, 24'h01, 4'd9},   // R9
    '{OP_RD,  6'h15, 24'h0D, 4'd9},   // R9
    '{OP_LN,  6'h00, 24'h000002, 4'd4}, // line1 rises, unmasked
    '{OP_RD,  6'h14, 24'h00, 4'd4},   // R4
    '{OP_LN,  6'h00, 24'h000003, 4'd2}, // line0 rises
    '{OP_RD,  6'h14, 24'h05, 4'd2},   // R2 edge + master
    '{OP_IRQ, 6'h00, 24'h01, 4'd7},   // R7
    '{OP_LN,  6'h00, 24'h000002, 4'd4}, // line0 falls, no fall mask
    '{OP_RD,  6'h14, 24'h05, 4'd4},   // R4 no overflow
    '{OP_LN,  6'h00, 24'h000003, 4'd5}, // line0 rises again
    '{OP_RD,  6'h14, 24'h07, 4'd5},   // R5 overflow
    '{OP_WR,  6'h07, 24'h08, 4'd6},   // clear edge
    '{OP_RD,  6'h14, 24'h02, 4'd6},   // R6 only overflow, ovf ie off
    '{OP_IRQ, 6'h00, 24'h00, 4'd7},   // R7
    '{OP_WR,  6'h07, 24'h04, 4'd6},   // clear overflow
    '{OP_RD,  6'h14, 24'h00, 4'd6},   // R6
    '{OP_WR,  6'h22, 24'h80, 4'd3},   // fall mask line23
    '{OP_WR,  6'h15, 24'h16, 4'd3},   // fall global, master, ovf ie
    '{OP_LN,  6'h00, 24'h800003, 4'd4}, // line23 rises, not enabled
    '{OP_RD,  6'h14, 24'h00, 4'd4},   // R4
    '{OP_LN,  6'h00, 24'h000003, 4'd3}, // line23 falls
    '{OP_RD,  6'h14, 24'h01, 4'd3},   // R3, edge ie off so no irq
    '{OP_IRQ, 6'h00, 24'h00, 4'd7},   // R7
    '{OP_LN,  6'h00, 24'h800003, 4'd5},
    '{OP_LN,  6'h00, 24'h000003, 4'd5}, // second fall
    '{OP_RD,  6'h14, 24'h07, 4'd5},   // R5 overflow drives irq
    '{OP_IRQ, 6'h00, 24'h01, 4'd7},   // R7
    '{OP_WR,  6'h15, 24'h00, 4'd8},   // disable all
    '{OP_IRQ, 6'h00, 24'h00, 4'd8},   // R8
    '{OP_RD,  6'h14, 24'h03, 4'd8},   // R8 flags kept
    '{OP_WR,  6'h07, 24'h0C, 4'd8},   // clear both
    '{OP_LN,  6'h00, 24'h800003, 4'd8},
    '{OP_LN,  6'h00, 24'h000003, 4'd8}, // fall with globals off
    '{OP_RD,  6'h14, 24'h00, 4'd8},   // R8 no detection
    '{OP_RD,  6'h3F, 24'h00, 4'd9},   // R9 unmapped
    '{OP_WR,  6'h15, 24'hFF, 4'd9},
    '{OP_RD,  6'h15, 24'h1F, 4'd9}    // R9 upper bits zero
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [23:0] lineIn = '0;
  logic        irqOut;
  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_change_irq dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .lineIn(lineIn), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic readChk(input string tag, input logic [5:0] a, input logic [7:0] exp);
    wrEn = 1'b0;
    addr = a;
    #1;
    check(tag, {16'h0, rdData}, {16'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wrEn = 1'b0;
      case (VEC[i].op)
        OP_WR: begin addr = VEC[i].addr; wrData = VEC[i].val[7:0]; wrEn = 1'b1; end
        OP_LN: lineIn = VEC[i].val;
        OP_RD: readChk($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].addr, VEC[i].val[7:0]);
        default: begin
          #1;
          check($sformatf("R%0d vector %0d irq", VEC[i].req, i), {23'h0, irqOut}, VEC[i].val);
        end
      endcase
    end
    // R6: clear and new rising edge on line0 in the same cycle; control is 0x1F
    @(negedge clk); wrEn = 1'b0; lineIn = 24'h000002;
    @(negedge clk); lineIn = 24'h000003;                 // edge pending
    @(negedge clk); lineIn = 24'h000002;
    @(negedge clk); addr = 6'h07; wrData = 8'h0C; wrEn = 1'b1; lineIn = 24'h000003;
    @(negedge clk); readChk("R6 set beats clear", 6'h14, 8'h07);
    #1; check("R7 irq with both flags", {23'h0, irqOut}, 24'h1);
    // R1: reset in mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    readChk("R1 status after reset", 6'h14, 8'h00);
    readChk("R1 control after reset", 6'h15, 8'h00);
    readChk("R1 fall mask after reset", 6'h22, 8'h00);
    #1; check("R1 irq after reset", {23'h0, irqOut}, 24'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule